// File: doc/BRIEF.md
# Pulse-Count Decimal Accumulator

This block is a four-decade binary-coded-decimal accumulator. It adds or subtracts a decimal operand by turning each operand digit into a burst of single-clock count pulses rather than by using a carry-lookahead adder. One operation takes a fixed frame of twelve clock intervals. During the first nine intervals every decade counts its own pulses in parallel. The last three intervals are set aside for carries or borrows, which move one decade per interval. A digit of value n is produced by ANDing the count enable with a window that is open for exactly n of the nine counting intervals. All nine windows are built from four base windows that are 1, 2, 4 and 8 intervals wide.

The block is meant to sit under a sequencer that builds products by repeated addition and decade shifts. Subtraction runs the decades in reverse, so results wrap in ten's complement. The operand can be scaled by ten on entry, and the top digit is lost, so that products can be kept modulo the register width. A single right shift by one decade and a clear (a train of right shifts) both use the same frame. No counting happens while either of them runs.

Top module: `pca_accum`

## Requirements
- R1: After synchronous reset, acc_o is 0000, and busy_o and done_o are both low.
- R2: A start_i sampled high while busy_o is low begins an operation. busy_o is high for the next 12 clocks. done_o is high for exactly one clock, on the 12th rising edge after the accepting edge, and acc_o then holds the final result.
- R3: Operation code 0 (add) leaves acc_o equal to (acc + operand) mod 10^4, in BCD with digit i in bits [4i+3:4i]. Every decade always holds a value from 0 to 9.
- R4: Operation code 1 (subtract) leaves acc_o equal to (acc - operand) mod 10^4, which is the ten's complement on underflow.
- R5: A carry (in add) or borrow (in subtract) that leaves a decade during the nine counting intervals is held. It reaches the next decade only in interval 9, 10 or 11, moving one decade per interval. After the 9th edge, 0999+0001 reads 0990, then 0900, then 0000, then 1000. Likewise 0000-0001 reads 0009, 0099, 0999, then 9999. No carry is left pending while the block is idle.
- R6: With lshift_i high at the accepting edge, the operand is multiplied by ten before use, and its top digit is dropped.
- R7: Operation code 2 shifts acc_o right by one decade on the first edge of the frame and fills the top decade with zero. opnd_i and lshift_i are ignored, and no other change happens in that frame.
- R8: Operation code 3 clears acc_o through one decade right shift per interval. acc_o is 0000 after the 4th edge of the frame and stays 0000.
- R9: start_i, op_i and opnd_i are ignored while busy_o is high. The running operation completes unchanged, and no new operation begins when it ends.
- R10: In an add or subtract, decade i changes value on exactly d of the nine counting edges, where d is the operand digit for that decade after any scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one interval per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request an operation when idle |
| op_i | input | 2 | 0 add, 1 subtract, 2 shift right, 3 clear |
| opnd_i | input | 16 | Four BCD operand digits, digit 0 in the low nibble |
| lshift_i | input | 1 | Scale the operand by ten before use |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse when the result is final |
| acc_o | output | 16 | Accumulator contents, four BCD digits |

## Verification
The bench checks every final result against a decimal reference model. It also traces acc_o at each edge of the frame. Fixed sums tell the deferred carry path apart from the counting path: a single carry and a full four-decade chain, both upward and downward, have known readings in intervals 9 to 11. Counting value changes per decade during the counting edges shows each digit window at its exact width for operands that use every digit value. A long run of random adds and subtracts, with and without scaling, separates modulo wrap from plain overflow. A start pulse injected mid-frame, and scaled operands with a non-zero top digit, cover the ignored inputs and the dropped digit.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int DEC_W   = 4;  // bits per decimal digit
    localparam int CNT_IVL = 9;  // intervals reserved for digit pulses

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_SHR = 2'd2,
        OP_CLR = 2'd3
    } pca_op_e;

    // Base count windows; a digit selects the OR of those its set bits name.
    typedef struct packed {
        logic w8;
        logic w4;
        logic w2;
        logic w1;
    } pca_win_t;

    // Window placement: w8 covers 0..7, w4 covers 2..5, w2 covers 6..7,
    // w1 covers 8. Any legal digit 0..9 combines only disjoint windows.
    function automatic pca_win_t base_windows(input int unsigned ivl);
        pca_win_t w;
        w.w8 = (ivl <= 32'd7);
        w.w4 = (ivl >= 32'd2) && (ivl <= 32'd5);
        w.w2 = (ivl == 32'd6) || (ivl == 32'd7);
        w.w1 = (ivl == 32'd8);
        return w;
    endfunction

    function automatic logic digit_gate(input logic [DEC_W-1:0] d, input pca_win_t w);
        return (d[3] & w.w8) | (d[2] & w.w4) | (d[1] & w.w2) | (d[0] & w.w1);
    endfunction

    // One count pulse on a decade, wrapping inside 0..9.
    function automatic logic [DEC_W-1:0] bcd_step(input logic [DEC_W-1:0] d, input logic dn);
        if (dn) begin
            return (d == '0) ? DEC_W'(9) : d - DEC_W'(1);
        end
        return (d == DEC_W'(9)) ? '0 : d + DEC_W'(1);
    endfunction

endpackage

// File: rtl/pca_timing.sv
module pca_timing #(
    parameter int CYC   = 12,
    parameter int IVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             last_o,
    output logic [IVL_W-1:0] ivl_o
);

    assign accept_o = start_i && !busy_o;
    assign last_o   = busy_o && (ivl_o == IVL_W'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            ivl_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                busy_o <= 1'b1;
                ivl_o  <= '0;
            end else if (last_o) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
                ivl_o  <= '0;
            end else if (busy_o) begin
                ivl_o <= ivl_o + IVL_W'(1);
            end
        end
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last_o) |=> busy_o); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (done_o && !busy_o)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !last_o) |=> (busy_o && ivl_o == $past(ivl_o) + IVL_W'(1))); // R9

endmodule

// File: rtl/pca_decade.sv
module pca_decade
    import pca_pkg::*;
#(
    parameter int DW = DEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_i,
    input  logic          cin_i,
    input  logic          dn_i,
    input  logic          rel_i,
    input  logic          flush_i,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_val_i,
    output logic [DW-1:0] dig_o,
    output logic          pend_o
);

    logic step;
    logic wrap;

    assign step = pulse_i | cin_i;
    assign wrap = step && (dn_i ? (dig_o == '0) : (dig_o == DW'(9)));

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_o <= '0;
        end else if (ld_i) begin
            dig_o <= ld_val_i;
        end else if (step) begin
            dig_o <= bcd_step(dig_o, dn_i);
        end
    end

    // Carry or borrow out is parked until a release interval.
    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            pend_o <= 1'b0;
        end else begin
            pend_o <= (pend_o & ~rel_i) | wrap;
        end
    end

    AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (rst)
        dig_o <= DW'(9)); // R3
    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !rel_i && !flush_i) |=> pend_o); // R5
    AST_PHASES_APART: assert property (@(posedge clk) disable iff (rst)
        !(pulse_i && cin_i)); // R5
    AST_SHIFT_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        ld_i |-> !step); // R7
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_i) |=> (dig_o != $past(dig_o))); // R10

endmodule

// File: rtl/pca_accum.sv
module pca_accum
    import pca_pkg::*;
#(
    parameter int NDIG = 4,
    parameter int DW   = DEC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [1:0]           op_i,
    input  logic [NDIG*DW-1:0]   opnd_i,
    input  logic                 lshift_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [NDIG*DW-1:0]   acc_o
);

    localparam int CAR_IVL = NDIG - 1;          // one ripple step per decade boundary
    localparam int CYC     = CNT_IVL + CAR_IVL;
    localparam int IVL_W   = $clog2(CYC);
    localparam int ACC_W   = NDIG * DW;

    logic             accept;
    logic             last;
    logic [IVL_W-1:0] ivl;
    pca_op_e          op_q;
    logic [ACC_W-1:0] opnd_q;
    logic             cnt_ph;
    logic             car_ph;
    logic             arith;
    logic             down;
    logic             shift_now;
    logic             flush;
    pca_win_t         win;
    logic [NDIG-1:0]  pulse;
    logic [NDIG-1:0]  pend;

    pca_timing #(
        .CYC   (CYC),
        .IVL_W (IVL_W)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .last_o   (last),
        .ivl_o    (ivl)
    );

    // Operation and (optionally scaled) operand are frozen for the frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_ADD;
            opnd_q <= '0;
        end else if (accept) begin
            op_q   <= pca_op_e'(op_i);
            opnd_q <= lshift_i ? {opnd_i[ACC_W-DW-1:0], {DW{1'b0}}} : opnd_i;
        end
    end

    assign cnt_ph    = busy_o && (ivl <  IVL_W'(CNT_IVL));
    assign car_ph    = busy_o && (ivl >= IVL_W'(CNT_IVL));
    assign arith     = (op_q == OP_ADD) || (op_q == OP_SUB);
    assign down      = (op_q == OP_SUB);
    assign shift_now = busy_o && (((op_q == OP_SHR) && (ivl == '0)) ||
                                  ((op_q == OP_CLR) && (ivl < IVL_W'(NDIG))));
    assign flush     = accept | last;
    assign win       = base_windows(32'(ivl));

    for (genvar i = 0; i < NDIG; i++) begin : g_dec
        logic [DW-1:0] op_dig;
        logic [DW-1:0] nb_dig;
        logic          cin;
        logic [DW-1:0] pcnt;

        assign op_dig   = opnd_q[i*DW +: DW];
        assign pulse[i] = arith && cnt_ph && digit_gate(op_dig, win);

        if (i == 0) begin : g_lsd
            assign cin = 1'b0;
        end else begin : g_upper
            assign cin = pend[i-1] & car_ph;
        end

        if (i == NDIG - 1) begin : g_msd
            assign nb_dig = '0;
        end else begin : g_lower
            assign nb_dig = acc_o[(i+1)*DW +: DW];
        end

        pca_decade #(
            .DW (DW)
        ) u_dec (
            .clk      (clk),
            .rst      (rst),
            .pulse_i  (pulse[i]),
            .cin_i    (cin),
            .dn_i     (down),
            .rel_i    (car_ph),
            .flush_i  (flush),
            .ld_i     (shift_now),
            .ld_val_i (nb_dig),
            .dig_o    (acc_o[i*DW +: DW]),
            .pend_o   (pend[i])
        );

        // Pulses delivered to this decade in the current frame.
        always_ff @(posedge clk) begin
            if (rst || accept) begin
                pcnt <= '0;
            end else if (pulse[i]) begin
                pcnt <= pcnt + DW'(1);
            end
        end

        AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
            (busy_o && arith && ivl == IVL_W'(CNT_IVL)) |-> (pcnt == op_dig)); // R10
    end

    AST_IDLE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (pend == '0)); // R5
    AST_SHR_ONE_DECADE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && op_q == OP_SHR && ivl == '0) |=>
        (acc_o == {{DW{1'b0}}, $past(acc_o[ACC_W-1:DW])})); // R7
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_CLR) |-> (acc_o == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !accept) |=> $stable(acc_o)); // R2

endmodule

// File: tb/tb_pca_accum.sv
module tb_pca_accum;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [15:0] opnd_i = 16'h0;
    logic        lshift_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] acc_o;

    pca_accum dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_i),
        .opnd_i   (opnd_i),
        .lshift_i (lshift_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .acc_o    (acc_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    int          n_cmp = 0;
    int          n_bad = 0;
    int          model = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] trc [0:12];

    function automatic int to_int(input logic [15:0] v);
        return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [15:0] to_bcd(input int x);
        int y;
        y = x % 10000;
        return {4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: each done pulse is matched against the queue.
    always @(negedge clk) begin
        logic [15:0] e;
        string       t;
        if (!rst && done_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R2 done without request", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(acc_o), int'(e));
            end
        end
    end

    // Driver: pushes the model result, runs one frame and traces acc_o.
    task automatic run_op(input logic [1:0] o, input logic [15:0] v, input logic ls,
                          input string tag, input bit poke);
        logic [15:0] eff;
        eff = ls ? {v[11:0], 4'h0} : v;
        case (o)
            2'd0:    model = (model + to_int(eff)) % 10000;
            2'd1:    model = (model + 10000 - to_int(eff)) % 10000;
            2'd2:    model = model / 10;
            default: model = 0;
        endcase
        exp_q.push_back(to_bcd(model));
        tag_q.push_back(tag);
        while (busy_o !== 1'b0) @(negedge clk);
        trc[0]   = acc_o;
        op_i     = o;
        opnd_i   = v;
        lshift_i = ls;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            if (poke && k == 4) begin
                start_i = 1'b1;
                op_i    = 2'd3;
                opnd_i  = 16'h0000;
            end
            if (poke && k == 6) start_i = 1'b0;
            @(negedge clk);
            trc[k] = acc_o;
            if (k >= 11) check("R2 busy/done timing", int'({busy_o, done_o}), (k == 12) ? 1 : 2);
        end
        if (o < 2'd2) begin
            for (int d = 0; d < 4; d++) begin
                int ch = 0;
                for (int k = 1; k <= 9; k++)
                    if (trc[k][4*d +: 4] !== trc[k-1][4*d +: 4]) ch++;
                check("R10 pulses per decade", ch, int'(eff[4*d +: 4]));
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset acc", int'(acc_o), 0);
        check("R1 reset busy/done", int'({busy_o, done_o}), 0);

        run_op(2'd0, 16'h3720, 1'b0, "R3 add 3720", 1'b0);

        run_op(2'd3, 16'h1234, 1'b0, "R8 clear", 1'b0);
        check("R8 first shift", int'(trc[1]), 16'h0372);
        check("R8 empty by edge 4", int'(trc[4]), 0);

        run_op(2'd0, 16'h0999, 1'b0, "R3 add 0999", 1'b0);
        run_op(2'd0, 16'h0001, 1'b0, "R5 add carry chain", 1'b0);
        check("R5 carry held at edge 9", int'(trc[9]), 16'h0990);
        check("R5 carry step edge 10", int'(trc[10]), 16'h0900);
        check("R5 carry step edge 11", int'(trc[11]), 16'h0000);
        check("R5 carry step edge 12", int'(trc[12]), 16'h1000);

        run_op(2'd1, 16'h1000, 1'b0, "R4 sub 1000", 1'b0);
        run_op(2'd1, 16'h0001, 1'b0, "R5 borrow chain", 1'b0);
        check("R5 borrow held at edge 9", int'(trc[9]), 16'h0009);
        check("R5 borrow step edge 10", int'(trc[10]), 16'h0099);
        check("R5 borrow step edge 11", int'(trc[11]), 16'h0999);
        check("R4 ten's complement", int'(trc[12]), 16'h9999);

        run_op(2'd0, 16'h0123, 1'b1, "R6 add scaled 0123", 1'b0);
        run_op(2'd0, 16'h5678, 1'b1, "R6 scaled top digit dropped", 1'b0);

        run_op(2'd2, 16'h9999, 1'b1, "R7 shift right", 1'b0);
        check("R7 shift on first edge", int'(trc[1]), 16'h0800);
        check("R7 no further change", int'(trc[12]), 16'h0800);

        run_op(2'd1, 16'h0456, 1'b0, "R4 sub 0456", 1'b0);

        run_op(2'd0, 16'h0111, 1'b0, "R9 start while busy ignored", 1'b1);
        @(negedge clk);
        check("R9 no late start", int'(busy_o), 0);
        check("R9 result kept", int'(acc_o), 16'h0455);

        for (int n = 0; n < 24; n++) begin
            logic [1:0]  o;
            logic [15:0] v;
            logic        ls;
            o  = 2'($urandom_range(0, 1));
            ls = 1'($urandom_range(0, 1));
            v  = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
                  4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            run_op(o, v, ls, (o == 2'd1) ? "R4 random sub" : "R3 random add", 1'b0);
        end

        repeat (3) @(negedge clk);
        check("R2 results outstanding", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule